// File: doc/BRIEF.md
# Dual-Port Word Store with Contention Flags and Mailbox Interrupts

This block is a 2048-word by 8-bit memory with two independent access ports, called left and right. Each port has an enable, a write select, an output enable, an 11-bit address and 8-bit write and read data. Both ports can reach every word. The whole design runs on one clock. A read returns its data on the cycle after the address is presented.

When both ports target the same word in one cycle and at least one of them is writing, the arbitration logic raises a busy flag to the losing port. That port's write is then discarded. Two reserved top words act as mailboxes. A write by one side into the other side's mailbox pulls that side's active-low interrupt low. The interrupt returns high when its owner reads the mailbox word.

Several of these blocks can be placed side by side to build wider words. In that case one block runs as the arbiter. The others run in follower mode, where they take the busy flags as inputs and do no arbitration of their own. The data and control pins are plain signals sampled every clock. Neither port has a valid/ready handshake, because an access always completes in a single cycle and there is nothing to back-pressure.

Top module: `dual_port_mailbox_ram`

## Requirements
- R1: A write with enable and write select high stores the data at the port's address. A read (enable high, write select low, output enable high) at cycle N puts the stored word on that port's read data at cycle N+1.
- R2: A port's read data is zero in cycle N+1 whenever, in cycle N, its enable was low, its output enable was low, or it was writing.
- R3: Two ports reading the same address in the same cycle raise no busy flag, and both get the stored word.
- R4: The two ports contend when both are enabled with equal addresses and at least one of them writes. If neither port was granted at that same address in the previous cycle, the right port's busy output goes high in that cycle and the left port's stays low. Without contention, both busy outputs are low.
- R5: During contention, a port that was granted at the same address in the previous cycle keeps the word. If only the right port holds the word in this way, the left port gets busy and the right port does not.
- R6: A write from a port whose effective busy is high leaves the memory unchanged. The effective busy is the internal decision in arbiter mode and the busy input in follower mode.
- R7: A granted write by the right port to address 0x7FF drives the left interrupt output low from the next cycle on. A granted read of 0x7FF by the left port drives it high again from the next cycle on. If both happen in the same cycle, the write wins.
- R8: A granted write by the left port to address 0x7FE drives the right interrupt output low from the next cycle on. A granted read of 0x7FE by the right port drives it high again from the next cycle on. If both happen in the same cycle, the write wins.
- R9: With follower mode high, both busy outputs stay low. Each port's busy input alone decides whether that port's writes are blocked.
- R10: A port whose enable is low changes neither the memory nor any interrupt, whatever its other inputs are.
- R11: While reset is high, and on the first cycle after it, both interrupt outputs are high and both read data buses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| slave_mode | input | 1 | 1 = follower mode, busy taken from the busy inputs |
| l_en | input | 1 | Left port enable |
| l_we | input | 1 | Left write select (1 = write) |
| l_oe | input | 1 | Left output enable |
| l_addr | input | 11 | Left word address |
| l_wdata | input | 8 | Left write data |
| l_rdata | output | 8 | Left read data, one cycle after the address |
| l_busy_in | input | 1 | Left busy from the arbiter block (follower mode) |
| l_busy_out | output | 1 | Left lost contention (arbiter mode) |
| l_irq_n | output | 1 | Left mailbox interrupt, active low |
| r_en | input | 1 | Right port enable |
| r_we | input | 1 | Right write select (1 = write) |
| r_oe | input | 1 | Right output enable |
| r_addr | input | 11 | Right word address |
| r_wdata | input | 8 | Right write data |
| r_rdata | output | 8 | Right read data, one cycle after the address |
| r_busy_in | input | 1 | Right busy from the arbiter block (follower mode) |
| r_busy_out | output | 1 | Right lost contention (arbiter mode) |
| r_irq_n | output | 1 | Right mailbox interrupt, active low |

## Verification
The hardest case to reach from the ports is R5. It needs a port that keeps one address over consecutive granted cycles while the other port arrives at that word with a write. Uniform random addresses almost never produce this.

The random stimulus therefore draws addresses from a few hot words and both mailbox words. It also reuses each port's previous address about half the time, so hold-then-collide sequences come up often. Directed sequences add a right-side hold that the left side then collides with, a simultaneous double write, and a disabled write aimed at a mailbox.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

  // Mailbox word owned by each side: the top word belongs to the left side,
  // the one below it to the right side.
  function automatic logic [31:0] mbox_word(input logic right_side, input int aw);
    logic [31:0] top;
    top = (32'd1 << aw) - 32'd1;
    return right_side ? top - 32'd1 : top;
  endfunction

endpackage

// File: rtl/dpm_arbiter.sv
module dpm_arbiter #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          slave_mode,
  input  logic          l_en,
  input  logic          l_we,
  input  logic [AW-1:0] l_addr,
  input  logic          l_busy_in,
  input  logic          r_en,
  input  logic          r_we,
  input  logic [AW-1:0] r_addr,
  input  logic          r_busy_in,
  output logic          l_busy_out,
  output logic          r_busy_out,
  output logic          l_block,
  output logic          r_block
);

  logic          l_pgo, r_pgo;
  logic [AW-1:0] l_paddr, r_paddr;
  logic          hit, l_cont, r_cont, l_lose, r_lose;

  // Same word, both enabled, at least one writer.
  assign hit    = l_en & r_en & (l_addr == r_addr) & (l_we | r_we);
  // A port continuing at the word it was granted last cycle holds it.
  assign l_cont = l_pgo & (l_paddr == l_addr);
  assign r_cont = r_pgo & (r_paddr == r_addr);
  assign l_lose = hit & r_cont & ~l_cont;
  assign r_lose = hit & ~l_lose;

  assign l_busy_out = ~slave_mode & l_lose;
  assign r_busy_out = ~slave_mode & r_lose;
  assign l_block    = slave_mode ? l_busy_in : l_lose;
  assign r_block    = slave_mode ? r_busy_in : r_lose;

  always_ff @(posedge clk) begin
    if (rst) begin
      l_pgo   <= 1'b0;
      r_pgo   <= 1'b0;
      l_paddr <= '0;
      r_paddr <= '0;
    end else begin
      l_pgo   <= l_en & ~l_block;
      r_pgo   <= r_en & ~r_block;
      l_paddr <= l_addr;
      r_paddr <= r_addr;
    end
  end

endmodule

// File: rtl/dpm_mailbox.sv
module dpm_mailbox #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          l_go,
  input  logic          l_we,
  input  logic [AW-1:0] l_addr,
  input  logic          r_go,
  input  logic          r_we,
  input  logic [AW-1:0] r_addr,
  output logic          l_irq_n,
  output logic          r_irq_n
);
  import dpm_pkg::*;

  localparam logic [AW-1:0] L_BOX = AW'(mbox_word(1'b0, AW));
  localparam logic [AW-1:0] R_BOX = AW'(mbox_word(1'b1, AW));

  logic l_set, l_clr, r_set, r_clr;

  assign l_set = r_go &  r_we & (r_addr == L_BOX);
  assign l_clr = l_go & ~l_we & (l_addr == L_BOX);
  assign r_set = l_go &  l_we & (l_addr == R_BOX);
  assign r_clr = r_go & ~r_we & (r_addr == R_BOX);

  always_ff @(posedge clk) begin
    if (rst) begin
      l_irq_n <= 1'b1;
      r_irq_n <= 1'b1;
    end else begin
      if (l_set)      l_irq_n <= 1'b0;
      else if (l_clr) l_irq_n <= 1'b1;
      if (r_set)      r_irq_n <= 1'b0;
      else if (r_clr) r_irq_n <= 1'b1;
    end
  end

endmodule

// File: rtl/dpm_storage.sv
module dpm_storage #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          wr,
  input  logic [1:0]          rd,
  input  logic [1:0][AW-1:0]  addr,
  input  logic [1:0][DW-1:0]  wdata,
  output logic [1:0][DW-1:0]  rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Index 0 is left, 1 is right; left is written last so it wins an overlap.
  always_ff @(posedge clk) begin
    if (wr[1]) mem[addr[1]] <= wdata[1];
    if (wr[0]) mem[addr[0]] <= wdata[0];
  end

  for (genvar p = 0; p < 2; p++) begin : g_rd
    always_ff @(posedge clk) begin
      if (rst)        rdata[p] <= '0;
      else if (rd[p]) rdata[p] <= mem[addr[p]];
      else            rdata[p] <= '0;
    end
  end

endmodule

// File: rtl/dual_port_mailbox_ram.sv
module dual_port_mailbox_ram #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          slave_mode,
  input  logic          l_en,
  input  logic          l_we,
  input  logic          l_oe,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  input  logic          l_busy_in,
  output logic          l_busy_out,
  output logic          l_irq_n,
  input  logic          r_en,
  input  logic          r_we,
  input  logic          r_oe,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata,
  input  logic          r_busy_in,
  output logic          r_busy_out,
  output logic          r_irq_n
);

  logic l_block, r_block, l_go, r_go;
  logic [1:0]         wr, rd;
  logic [1:0][AW-1:0] addr;
  logic [1:0][DW-1:0] wdata, rdata;

  dpm_arbiter #(.AW(AW)) arb_i (
    .clk(clk), .rst(rst), .slave_mode(slave_mode),
    .l_en(l_en), .l_we(l_we), .l_addr(l_addr), .l_busy_in(l_busy_in),
    .r_en(r_en), .r_we(r_we), .r_addr(r_addr), .r_busy_in(r_busy_in),
    .l_busy_out(l_busy_out), .r_busy_out(r_busy_out),
    .l_block(l_block), .r_block(r_block)
  );

  assign l_go = l_en & ~l_block;
  assign r_go = r_en & ~r_block;

  dpm_mailbox #(.AW(AW)) mbx_i (
    .clk(clk), .rst(rst),
    .l_go(l_go), .l_we(l_we), .l_addr(l_addr),
    .r_go(r_go), .r_we(r_we), .r_addr(r_addr),
    .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
  );

  assign wr    = {r_go & r_we, l_go & l_we};
  assign rd    = {r_en & r_oe & ~r_we, l_en & l_oe & ~l_we};
  assign addr  = {r_addr, l_addr};
  assign wdata = {r_wdata, l_wdata};

  dpm_storage #(.AW(AW), .DW(DW)) mem_i (
    .clk(clk), .rst(rst), .wr(wr), .rd(rd),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  assign l_rdata = rdata[0];
  assign r_rdata = rdata[1];

endmodule

// File: rtl/dpm_chk.sv
module dpm_chk #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          slave_mode,
  input logic          l_en,
  input logic          l_we,
  input logic          l_oe,
  input logic [AW-1:0] l_addr,
  input logic [DW-1:0] l_wdata,
  input logic [DW-1:0] l_rdata,
  input logic          l_busy_in,
  input logic          l_busy_out,
  input logic          l_irq_n,
  input logic          r_en,
  input logic          r_we,
  input logic          r_oe,
  input logic [AW-1:0] r_addr,
  input logic [DW-1:0] r_wdata,
  input logic [DW-1:0] r_rdata,
  input logic          r_busy_in,
  input logic          r_busy_out,
  input logic          r_irq_n
);
  localparam logic [AW-1:0] L_BOX = {AW{1'b1}};
  localparam logic [AW-1:0] R_BOX = {{(AW-1){1'b1}}, 1'b0};

  logic l_eff, r_eff, clash;
  assign l_eff = slave_mode ? l_busy_in : l_busy_out;
  assign r_eff = slave_mode ? r_busy_in : r_busy_out;
  assign clash = l_en & r_en & (l_addr == r_addr) & (l_we | r_we);

  // R4
  busy_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(l_busy_out && r_busy_out));

  // R4
  contention_flagged_chk: assert property (@(posedge clk) disable iff (rst)
    (!slave_mode && clash) |-> (l_busy_out || r_busy_out));

  // R3
  no_spurious_busy_chk: assert property (@(posedge clk) disable iff (rst)
    !clash |-> (!l_busy_out && !r_busy_out));

  // R9
  follower_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    slave_mode |-> (!l_busy_out && !r_busy_out));

  // R7
  left_irq_set_chk: assert property (@(posedge clk) disable iff (rst)
    (r_en && r_we && r_addr == L_BOX && !r_eff) |=> !l_irq_n);

  // R8
  right_irq_set_chk: assert property (@(posedge clk) disable iff (rst)
    (l_en && l_we && l_addr == R_BOX && !l_eff) |=> !r_irq_n);

  // R2
  left_rdata_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !(l_en && l_oe && !l_we) |=> (l_rdata == '0));

  // R11
  reset_irq_chk: assert property (@(posedge clk)
    rst |=> (l_irq_n && r_irq_n && l_rdata == '0 && r_rdata == '0));

endmodule

bind dual_port_mailbox_ram dpm_chk #(.AW(AW), .DW(DW)) chk_i (.*);

// File: tb/dual_port_mailbox_ram_tb.sv
`timescale 1ns/1ps
module dual_port_mailbox_ram_tb_top;

  localparam int AW = 11;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] L_BOX = 11'h7FF;
  localparam logic [AW-1:0] R_BOX = 11'h7FE;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic slave = 1'b0;
  logic le = 0, lw = 0, loe = 0, lbi = 0;
  logic re = 0, rw = 0, roe = 0, rbi = 0;
  logic [AW-1:0] la = '0, ra = '0;
  logic [DW-1:0] lwd = '0, rwd = '0;
  logic [DW-1:0] l_rdata, r_rdata;
  logic l_busy_out, r_busy_out, l_irq_n, r_irq_n;

  always #4 clk = ~clk;

  dual_port_mailbox_ram #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst(rst), .slave_mode(slave),
    .l_en(le), .l_we(lw), .l_oe(loe), .l_addr(la), .l_wdata(lwd),
    .l_rdata(l_rdata), .l_busy_in(lbi), .l_busy_out(l_busy_out), .l_irq_n(l_irq_n),
    .r_en(re), .r_we(rw), .r_oe(roe), .r_addr(ra), .r_wdata(rwd),
    .r_rdata(r_rdata), .r_busy_in(rbi), .r_busy_out(r_busy_out), .r_irq_n(r_irq_n)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [DW-1:0] mem_m [DEPTH];
  logic pgl = 0, pgr = 0;
  logic [AW-1:0] pal = '0, par = '0;
  logic irql_m = 1, irqr_m = 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // One access cycle; inputs are already driven (we sit just after a negedge).
  task automatic run_cycle();
    logic hit, lc, rc, lb, rb, effl, effr, gl, gr, lrd, rrd, lchk, rchk;
    logic [DW-1:0] le_d, re_d;
    string tag;
    #1;
    hit = le && re && (la == ra) && (lw || rw);
    lc  = pgl && (pal == la);
    rc  = pgr && (par == ra);
    lb  = hit && rc && !lc;
    rb  = hit && !lb;
    if (slave) tag = "R9";
    else if (hit) tag = lb ? "R5" : "R4";
    else if (le && re && la == ra) tag = "R3";
    else tag = "R4";
    check(l_busy_out == (!slave && lb), tag, l_busy_out, !slave && lb);
    check(r_busy_out == (!slave && rb), tag, r_busy_out, !slave && rb);
    effl = slave ? lbi : lb;
    effr = slave ? rbi : rb;
    gl = le && !effl;
    gr = re && !effr;
    lrd = le && loe && !lw;
    rrd = re && roe && !rw;
    le_d = lrd ? mem_m[la] : '0;
    re_d = rrd ? mem_m[ra] : '0;
    lchk = !(lrd && (effl || (gr && rw && ra == la)));
    rchk = !(rrd && (effr || (gl && lw && la == ra)));
    if (gr && rw) mem_m[ra] = rwd;
    if (gl && lw) mem_m[la] = lwd;
    if (gr && rw && ra == L_BOX) irql_m = 0;
    else if (gl && !lw && la == L_BOX) irql_m = 1;
    if (gl && lw && la == R_BOX) irqr_m = 0;
    else if (gr && !rw && ra == R_BOX) irqr_m = 1;
    pgl = gl; pgr = gr; pal = la; par = ra;
    @(posedge clk);
    #1;
    if (lchk) check(l_rdata === le_d, lrd ? "R1 left" : "R2 left", l_rdata, le_d);
    if (rchk) check(r_rdata === re_d, rrd ? "R1 right" : "R2 right", r_rdata, re_d);
    check(l_irq_n === irql_m, "R7", l_irq_n, irql_m);
    check(r_irq_n === irqr_m, "R8", r_irq_n, irqr_m);
    @(negedge clk);
  endtask

  task automatic set_l(input logic en, input logic we, input logic oe,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    le = en; lw = we; loe = oe; la = a; lwd = d;
  endtask

  task automatic set_r(input logic en, input logic we, input logic oe,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    re = en; rw = we; roe = oe; ra = a; rwd = d;
  endtask

  task automatic idle();
    set_l(0, 0, 0, '0, '0);
    set_r(0, 0, 0, '0, '0);
    run_cycle();
  endtask

  function automatic logic [AW-1:0] pick_addr(input logic [AW-1:0] prev);
    int k;
    k = $urandom % 10;
    if (k < 4) return prev;
    if (k < 7) return AW'($urandom % 4);
    if (k == 7) return L_BOX;
    if (k == 8) return R_BOX;
    return AW'($urandom);
  endfunction

  task automatic rand_cycle();
    int k;
    le = ($urandom % 4) != 0;
    lw = ($urandom % 2) != 0;
    loe = ($urandom % 5) != 0;
    la = pick_addr(la);
    lwd = DW'($urandom);
    re = ($urandom % 4) != 0;
    rw = ($urandom % 2) != 0;
    roe = ($urandom % 5) != 0;
    ra = pick_addr(ra);
    rwd = DW'($urandom);
    k = $urandom % 10;
    lbi = slave && (k < 3);
    rbi = slave && (($urandom % 10) < 3);
    run_cycle();
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired at %0t", $time);
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R11 reset state
    check(l_irq_n === 1'b1 && r_irq_n === 1'b1, "R11 irq", {l_irq_n, r_irq_n}, 2'b11);
    check(l_rdata === '0 && r_rdata === '0, "R11 rdata", {l_rdata, r_rdata}, 0);
    check(!l_busy_out && !r_busy_out, "R11 busy", {l_busy_out, r_busy_out}, 0);
    rst = 0;

    // Preload every word from the left port, then clear the right mailbox.
    for (int a = 0; a < DEPTH; a++) begin
      set_l(1, 1, 0, AW'(a), DW'(a) ^ 8'h5A);
      run_cycle();
    end
    set_l(0, 0, 0, '0, '0);
    set_r(1, 0, 1, R_BOX, '0);
    run_cycle();
    idle();

    // R3: both read the same word.
    set_l(1, 0, 1, 11'd12, '0);
    set_r(1, 0, 1, 11'd12, '0);
    run_cycle();
    check(l_rdata === (8'd12 ^ 8'h5A) && r_rdata === (8'd12 ^ 8'h5A), "R3 data",
          {l_rdata, r_rdata}, {2{8'd12 ^ 8'h5A}});
    idle();

    // R4: simultaneous writes to a fresh word, left wins.
    set_l(1, 1, 0, 11'd5, 8'hA1);
    set_r(1, 1, 0, 11'd5, 8'hB2);
    #1;
    check(r_busy_out && !l_busy_out, "R4 simultaneous", {l_busy_out, r_busy_out}, 2'b01);
    run_cycle();
    set_l(1, 0, 1, 11'd5, '0);
    set_r(0, 0, 0, '0, '0);
    run_cycle();
    check(l_rdata === 8'hA1, "R6 right write blocked", l_rdata, 8'hA1);
    idle();

    // R5: right holds word 9, left arrives with a write and loses.
    set_r(1, 0, 1, 11'd9, '0);
    run_cycle();
    set_l(1, 1, 0, 11'd9, 8'hEE);
    #1;
    check(l_busy_out && !r_busy_out, "R5 holder keeps word", {l_busy_out, r_busy_out}, 2'b10);
    run_cycle();
    set_l(1, 0, 1, 11'd9, '0);
    set_r(0, 0, 0, '0, '0);
    run_cycle();
    check(l_rdata === (8'd9 ^ 8'h5A), "R6 left write blocked", l_rdata, 8'd9 ^ 8'h5A);
    idle();

    // R7: right posts to left mailbox, left reads it back.
    set_r(1, 1, 0, L_BOX, 8'h3C);
    run_cycle();
    check(l_irq_n === 1'b0, "R7 set", l_irq_n, 0);
    set_r(0, 0, 0, '0, '0);
    set_l(1, 0, 1, L_BOX, '0);
    run_cycle();
    check(l_irq_n === 1'b1 && l_rdata === 8'h3C, "R7 clear", {l_irq_n, l_rdata}, {1'b1, 8'h3C});
    idle();

    // R10: disabled write to the right mailbox does nothing.
    set_l(0, 1, 1, R_BOX, 8'h77);
    run_cycle();
    check(r_irq_n === 1'b1, "R10 no irq", r_irq_n, 1);
    set_l(0, 0, 0, '0, '0);
    set_r(1, 0, 1, R_BOX, '0);
    run_cycle();
    check(r_rdata === (8'hFE ^ 8'h5A), "R10 memory kept", r_rdata, 8'hFE ^ 8'h5A);
    idle();

    // R2: output enable low gives zero.
    set_l(1, 0, 0, 11'd3, '0);
    run_cycle();
    check(l_rdata === '0, "R2 oe low", l_rdata, 0);
    idle();

    // R8 via directed post, then random traffic in both modes.
    set_l(1, 1, 0, R_BOX, 8'h42);
    run_cycle();
    check(r_irq_n === 1'b0, "R8 set", r_irq_n, 0);
    idle();
    for (int i = 0; i < 3000; i++) rand_cycle();
    idle();
    slave = 1;
    // R9: follower mode, busy input blocks a write.
    set_l(1, 1, 0, 11'd20, 8'h99);
    lbi = 1;
    #1;
    check(!l_busy_out && !r_busy_out, "R9 outputs low", {l_busy_out, r_busy_out}, 0);
    run_cycle();
    lbi = 0;
    set_l(1, 0, 1, 11'd20, '0);
    run_cycle();
    check(l_rdata === mem_m[20] && l_rdata !== 8'h99, "R9 blocked write", l_rdata, mem_m[20]);
    for (int i = 0; i < 1500; i++) rand_cycle();
    lbi = 0; rbi = 0;
    finish_run();
  end

endmodule